// File: doc/BRIEF.md
# Forward-Only Operator Interconnect

This block routes results between the processing operators of a reconfigurable datapath. There are N operators, numbered 0 to N-1. Each has one result output and two operand inputs. An operand input of operator j can be fed only from operators j-1 down to j-W, where W = N/2. Lower-numbered operators that fall inside this window are the only possible sources. Connections therefore always point forward, and no pattern can form a loop. The last operator's result is never a source, so it does not enter the block.

Every possible connector has its own enable bit, so one result may feed any number of inputs at the same time. The pattern is held in two banks. Software-side logic writes a complete new pattern into the staged bank while the active bank keeps routing. A single swap strobe then moves the staged pattern into the active bank in one clock.

An operand input with no enabled connector delivers zero and is marked not valid. An input with several enabled connectors also delivers zero and is marked not valid, and a pattern-wide error flag is raised. All routed values pass through the same fixed number of register stages, so the network never stalls.

Top module: `fwd_op_net`

## Requirements
- R1: `cfg_load` writes `cfg_data` into the staged bank at the clock edge. A staged pattern has no effect on `op_in`, `op_in_vld` or `cfg_err` until it is swapped in.
- R2: `cfg_swap` copies the staged bank into the active bank at the clock edge. `cfg_err` reflects the new pattern from the cycle after that edge. `op_in` and `op_in_vld` reflect the new pattern LAT edges after it. If `cfg_load` and `cfg_swap` are asserted together, the previously staged pattern is the one made active.
- R3: With W = N_OPS/2 and c(j) = min(j, W), the connector that carries operator j-k (k = 1..c(j)) to input p of operator j (p = 0 or 1) is enabled by bit B(j,p)+k-1 of the pattern. Here B(j,p) = 2*(c(0)+...+c(j-1)) + p*c(j). An enabled, unique connector drives `op_in[(2j+p)*DW +: DW]` with `op_res[(j-k)*DW +: DW]` and sets `op_in_vld[2j+p]`.
- R4: One operator result may be enabled onto several inputs at once, and each of them carries it.
- R5: An input with no enabled connector drives zero with its valid bit low. This always applies to both inputs of operator 0.
- R6: An input with more than one enabled connector drives zero with its valid bit low. `cfg_err` is high for as long as any such input exists in the active pattern.
- R7: A change on `op_res` appears on `op_in` exactly LAT clock edges later, with the same delay on every path and no stall cycles.
- R8: Reset clears both banks and all pipeline stages. While reset is held and afterwards, `op_in` and `op_in_vld` are zero and `cfg_err` is low until a non-empty pattern is swapped in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Write `cfg_data` into the staged bank |
| cfg_data | input | NB (44 by default) | New connector pattern, one enable bit per connector |
| cfg_swap | input | 1 | Make the staged pattern active |
| op_res | input | (N_OPS-1)*DW | Results of operators 0 to N_OPS-2, operator i at slice i*DW |
| op_in | output | 2*N_OPS*DW | Routed operand values, input p of operator j at slice (2j+p)*DW |
| op_in_vld | output | 2*N_OPS | Input (2j+p) has exactly one enabled source |
| cfg_err | output | 1 | Active pattern has an input with conflicting enables |

## Verification
The bench builds the block with N_OPS = 8, DW = 8 and LAT = 2. This gives a window of four and a 44-bit pattern. Operators 1 to 3 then have fewer candidates than the window, while operators 4 to 7 have the full window, including the longest reach from operator 3 to operator 7. Two stages of latency let the bench watch a value routed under the old pattern still in flight after a swap, and a new operand value arriving one edge after the last old one.

// File: rtl/fon_pkg.sv
`timescale 1ns/1ps
package fon_pkg;

    // Number of candidate sources for any input of operator dst.
    function automatic int conn_cnt(input int dst, input int win);
        return (dst < win) ? dst : win;
    endfunction

    // First pattern bit that belongs to input port of operator dst.
    function automatic int conn_base(input int dst, input int port, input int win);
        int b;
        b = 0;
        for (int m = 0; m < dst; m++) begin
            b += 2 * conn_cnt(m, win);
        end
        return b + port * conn_cnt(dst, win);
    endfunction

    // Total pattern width for n operators.
    function automatic int cfg_bits(input int n, input int win);
        return conn_base(n, 0, win);
    endfunction

    typedef struct packed {
        logic hit;    // exactly one enabled source
        logic clash;  // two or more enabled sources
    } sel_stat_t;

endpackage

// File: rtl/fon_cfg_bank.sv
`timescale 1ns/1ps
module fon_cfg_bank #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NB-1:0] data,
    input  logic          swap,
    output logic [NB-1:0] stg,
    output logic [NB-1:0] act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
            act <= '0;
        end else begin
            if (load) stg <= data;
            if (swap) act <= stg;
        end
    end

endmodule

// File: rtl/fon_input_sel.sv
`timescale 1ns/1ps
module fon_input_sel import fon_pkg::*; #(
    parameter int DW = 16,
    parameter int NC = 1
) (
    input  logic [NC-1:0]    en,
    input  logic [NC*DW-1:0] cand,
    output logic [DW-1:0]    dout,
    output sel_stat_t        st
);

    logic [DW-1:0] merged;
    int            n_on;

    always_comb begin
        merged = '0;
        for (int k = 0; k < NC; k++) begin
            if (en[k]) merged |= cand[k*DW +: DW];
        end
        n_on     = $countones(en);
        st.hit   = (n_on == 1);
        st.clash = (n_on > 1);
        dout     = st.hit ? merged : '0;
    end

endmodule

// File: rtl/fon_delay.sv
`timescale 1ns/1ps
module fon_delay #(
    parameter int WIDTH = 1,
    parameter int LAT   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LAT; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < LAT; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[LAT-1];

endmodule

// File: rtl/fwd_op_net.sv
`timescale 1ns/1ps
module fwd_op_net import fon_pkg::*; #(
    parameter int N_OPS  = 8,
    parameter int DW     = 16,
    parameter int LAT    = 2,
    localparam int WIN   = N_OPS / 2,
    localparam int NB    = cfg_bits(N_OPS, WIN),
    localparam int NIN   = 2 * N_OPS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_load,
    input  logic [NB-1:0]          cfg_data,
    input  logic                   cfg_swap,
    input  logic [(N_OPS-1)*DW-1:0] op_res,
    output logic [NIN*DW-1:0]      op_in,
    output logic [NIN-1:0]         op_in_vld,
    output logic                   cfg_err
);

    logic [NB-1:0]     stg_cfg;
    logic [NB-1:0]     act_cfg;
    logic [NIN*DW-1:0] sel_data;
    logic [NIN-1:0]    sel_hit;
    logic [NIN-1:0]    sel_clash;

    fon_cfg_bank #(.NB(NB)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .data (cfg_data),
        .swap (cfg_swap),
        .stg  (stg_cfg),
        .act  (act_cfg)
    );

    for (genvar j = 0; j < N_OPS; j++) begin : g_op
        for (genvar p = 0; p < 2; p++) begin : g_port
            localparam int NC   = conn_cnt(j, WIN);
            localparam int BASE = conn_base(j, p, WIN);
            localparam int IX   = 2 * j + p;
            if (NC == 0) begin : g_none
                assign sel_data[IX*DW +: DW] = '0;
                assign sel_hit[IX]           = 1'b0;
                assign sel_clash[IX]         = 1'b0;
            end else begin : g_mux
                logic [NC*DW-1:0] cand;
                sel_stat_t        st;
                // Candidate k carries operator j-1-k (distance k+1).
                for (genvar k = 0; k < NC; k++) begin : g_cand
                    assign cand[k*DW +: DW] = op_res[(j-1-k)*DW +: DW];
                end
                fon_input_sel #(.DW(DW), .NC(NC)) u_sel (
                    .en   (act_cfg[BASE +: NC]),
                    .cand (cand),
                    .dout (sel_data[IX*DW +: DW]),
                    .st   (st)
                );
                assign sel_hit[IX]   = st.hit;
                assign sel_clash[IX] = st.clash;
            end
        end
    end

    assign cfg_err = |sel_clash;

    fon_delay #(.WIDTH(NIN*DW + NIN), .LAT(LAT)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  ({sel_hit, sel_data}),
        .dout ({op_in_vld, op_in})
    );

endmodule

// File: rtl/fon_chk.sv
`timescale 1ns/1ps
module fon_chk #(
    parameter int N_OPS = 8,
    parameter int DW    = 16,
    parameter int NB    = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_load,
    input logic [NB-1:0]         cfg_data,
    input logic                  cfg_swap,
    input logic [NB-1:0]         stg,
    input logic [NB-1:0]         act,
    input logic [2*N_OPS*DW-1:0] op_in,
    input logic [2*N_OPS-1:0]    op_in_vld,
    input logic                  cfg_err
);

    AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (stg == $past(cfg_data)));  // R1

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_swap |=> $stable(act));  // R1

    AST_SWAP_COPY: assert property (@(posedge clk) disable iff (rst)
        cfg_swap |=> (act == $past(stg)));  // R2

    AST_ERR_ONLY_ON_SWAP: assert property (@(posedge clk) disable iff (rst)
        !cfg_swap |=> $stable(cfg_err));  // R6

    for (genvar i = 0; i < 2*N_OPS; i++) begin : g_inv
        AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
            !op_in_vld[i] |-> (op_in[i*DW +: DW] == '0));  // R5
    end

endmodule

bind fwd_op_net fon_chk #(.N_OPS(N_OPS), .DW(DW), .NB(NB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_data  (cfg_data),
    .cfg_swap  (cfg_swap),
    .stg       (stg_cfg),
    .act       (act_cfg),
    .op_in     (op_in),
    .op_in_vld (op_in_vld),
    .cfg_err   (cfg_err)
);

// File: tb/test_fwd_op_net.sv
`timescale 1ns/1ps
module test_fwd_op_net;

    localparam int N   = 8;
    localparam int DW  = 8;
    localparam int LAT = 2;
    localparam int NB  = 44;

    // Dense bench-side pattern: bit (2j+p)*4 + k-1 enables source j-k for input p of op j.
    typedef struct packed {
        logic [63:0] dense;
        logic        err;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{64'h0101_0101_0101_0100, 1'b0},  // R3 chain: op j input 0 from op j-1
        '{64'h0000_0080_0420_0100, 1'b0},  // R4 fan-out of op0 at distances 1..4
        '{64'h0001_3000_0000_0000, 1'b1},  // R6 clash on op5 input 1
        '{64'h0000_0000_0002_1100, 1'b0},  // R3 op1 both inputs, op2 input 0 from op0
        '{64'h0000_0000_0000_0000, 1'b0},  // R5 empty pattern
        '{64'h1800_0000_0000_0000, 1'b0},  // R3 widest reach op3 -> op7
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1}   // R6 everything enabled
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 cfg_load;
    logic [NB-1:0]        cfg_data;
    logic                 cfg_swap;
    logic [(N-1)*DW-1:0]  op_res;
    logic [2*N*DW-1:0]    op_in;
    logic [2*N-1:0]       op_in_vld;
    logic                 cfg_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fwd_op_net #(.N_OPS(N), .DW(DW), .LAT(LAT)) i_fwd_op_net (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_data  (cfg_data),
        .cfg_swap  (cfg_swap),
        .op_res    (op_res),
        .op_in     (op_in),
        .op_in_vld (op_in_vld),
        .cfg_err   (cfg_err)
    );

    function automatic logic [NB-1:0] pack(input logic [63:0] dense);
        logic [NB-1:0] v;
        int pos;
        v = '0;
        pos = 0;
        for (int j = 0; j < N; j++)
            for (int p = 0; p < 2; p++)
                for (int k = 1; k <= 4; k++)
                    if (k <= j) begin
                        v[pos] = dense[(2*j+p)*4 + k-1];
                        pos++;
                    end
        return v;
    endfunction

    task automatic model(input logic [63:0] dense, input logic [(N-1)*DW-1:0] res,
                         output logic [2*N*DW-1:0] d, output logic [2*N-1:0] v);
        d = '0;
        v = '0;
        for (int j = 0; j < N; j++)
            for (int p = 0; p < 2; p++) begin
                int cnt;
                int src;
                cnt = 0;
                src = 0;
                for (int k = 1; k <= 4; k++)
                    if (k <= j && dense[(2*j+p)*4 + k-1]) begin
                        cnt++;
                        src = j - k;
                    end
                if (cnt == 1) begin
                    d[(2*j+p)*DW +: DW] = res[src*DW +: DW];
                    v[2*j+p] = 1'b1;
                end
            end
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_pattern(input string tag, input logic [63:0] dense);
        logic [2*N*DW-1:0] d;
        logic [2*N-1:0]    v;
        model(dense, op_res, d, v);
        chk({tag, " data"}, 128'(op_in), 128'(d));
        chk({tag, " valid"}, 128'(op_in_vld), 128'(v));
    endtask

    task automatic install(input logic [63:0] dense);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_data = pack(dense);
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_swap = 1'b1;
        @(negedge clk);
        cfg_swap = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        cfg_load = 1'b0;
        cfg_swap = 1'b0;
        cfg_data = '0;
        for (int i = 0; i < N-1; i++) op_res[i*DW +: DW] = 8'(8'h11 * (i + 1));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        chk("R8 data", 128'(op_in), 128'd0);
        chk("R8 valid", 128'(op_in_vld), 128'd0);
        chk("R8 err", 128'(cfg_err), 128'd0);

        // Table walk: R3, R4, R5, R6
        for (int t = 0; t < 7; t++) begin
            install(VECS[t].dense);
            chk_pattern("R3 table", VECS[t].dense);
            chk("R6 table err", 128'(cfg_err), 128'(VECS[t].err));
        end

        // R5: operator 0 inputs never driven even with all bits set
        chk("R5 op0 valid", 128'(op_in_vld[1:0]), 128'd0);

        // R1: staging a clashing pattern leaves the active one untouched
        install(VECS[0].dense);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_data = pack(VECS[2].dense);
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (4) @(negedge clk);
        chk_pattern("R1 staged hidden", VECS[0].dense);
        chk("R1 err hidden", 128'(cfg_err), 128'd0);

        // R2: swap timing
        cfg_swap = 1'b1;
        @(negedge clk);
        cfg_swap = 1'b0;
        chk("R2 err next cycle", 128'(cfg_err), 128'd1);
        chk_pattern("R2 old in flight", VECS[0].dense);
        repeat (LAT-1) begin
            @(negedge clk);
            chk_pattern("R2 old in flight", VECS[0].dense);
        end
        @(negedge clk);
        chk_pattern("R2 new at latency", VECS[2].dense);

        // R2: load and swap together activate the earlier staged pattern
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_data = pack(VECS[5].dense);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_swap = 1'b1;
        cfg_data = pack(VECS[1].dense);
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_swap = 1'b0;
        repeat (LAT) @(negedge clk);
        chk_pattern("R2 load+swap", VECS[5].dense);
        @(negedge clk);
        cfg_swap = 1'b1;
        @(negedge clk);
        cfg_swap = 1'b0;
        repeat (LAT) @(negedge clk);
        chk_pattern("R2 second swap", VECS[1].dense);

        // R4: op0 result fans out to four inputs
        chk("R4 op1.in0", 128'(op_in[2*DW +: DW]), 128'(op_res[0 +: DW]));
        chk("R4 op2.in1", 128'(op_in[5*DW +: DW]), 128'(op_res[0 +: DW]));
        chk("R4 op3.in0", 128'(op_in[6*DW +: DW]), 128'(op_res[0 +: DW]));
        chk("R4 op4.in1", 128'(op_in[9*DW +: DW]), 128'(op_res[0 +: DW]));

        // R7: fixed latency on every path of the chain
        install(VECS[0].dense);
        @(negedge clk);
        begin
            logic [63:0] old_dense;
            old_dense = VECS[0].dense;
            for (int i = 0; i < N-1; i++) op_res[i*DW +: DW] = 8'(8'hA0 + i);
            // Outputs still show the old values until LAT edges have passed.
            repeat (LAT-1) begin
                @(negedge clk);
                chk("R7 old value held", 128'(op_in[2*DW +: DW]), 128'h11);
            end
            @(negedge clk);
            chk_pattern("R7 new values", old_dense);
        end

        // R8: reset mid-run clears everything, including the staged bank
        install(VECS[2].dense);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 mid data", 128'(op_in), 128'd0);
        chk("R8 mid valid", 128'(op_in_vld), 128'd0);
        chk("R8 mid err", 128'(cfg_err), 128'd0);
        cfg_swap = 1'b1;
        @(negedge clk);
        cfg_swap = 1'b0;
        repeat (LAT) @(negedge clk);
        chk("R8 staged cleared", 128'(op_in_vld), 128'd0);
        chk("R8 staged err", 128'(cfg_err), 128'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule